// File: doc/BRIEF.md
# Capability PTE permission checker

This block judges one page-table entry against one memory access on behalf of a page-table walker. It applies the usual read, write, execute and user/supervisor rules. On top of those it applies a ten-bit extension field that controls capabilities. That field can refuse tagged-capability stores. For capability loads it picks one of three outcomes: the tag is kept (OK), the tag is stripped (CLEAR), or a tagged load faults (TRAP). TRAP can also come from a generation mismatch, where a bit in the entry is compared with one of two global generation bits. The entry's own user bit picks which of the two is used.

A check is presented with `chk_valid` and its result appears, registered, one cycle later. The block also keeps a walk-wide load mode. The walker raises `walk_start` on the first level of a walk. Each passing check then folds its load mode into that accumulator, and the fold never moves the mode back down. Two build-time options select the variant. One drops the extension field in favour of a fixed permissive value, for walks whose entries carry no such bits. The other takes the global generation bits from the machine-level register when no supervisor level exists.

Top module: `cap_pte_checker`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `res_valid` is 0 and `acc_lc` is 0 (OK).
- R2: Flag bits are V=bit0, R=bit1, W=bit2, X=bit3, U=bit4. Extension bits are store-enable (SE)=bit9, load-enable (LE)=bit8, load-trap (LT)=bit6, generation (GN)=bit5. The entry is invalid, with `res_cause`=1, when any of these holds: V=0; W=1 and R=0; LE=0 and GN=1; LE=1, GN=1 and LT=0.
- R3: `acc_op` encodes 0=read, 1=write, 2=read-modify-write, 3=execute. `priv_sup` is 1 for supervisor. A user access needs U=1. A supervisor access needs U=0 or `sum`=1, but supervisor execute always needs U=0. Reads need R, or X with `mxr`. Writes need W. A read-modify-write needs both the read and the write condition. Execute needs X. A failure here gives `res_cause`=2. It outranks every capability failure, but invalid (R2) outranks it.
- R4: After R2 and R3 pass, a write, or a read-modify-write with `wr_is_cap`=1, fails with `res_cause`=3 when SE=0. Data stores pass whatever SE holds.
- R5: `res_lc` encodes 0=OK, 1=CLEAR, 2=TRAP. For a passing read or read-modify-write with `rd_is_cap`=1, {LE,LT}={0,0} gives CLEAR, {0,1} gives TRAP and {1,0} gives OK.
- R6: With LE=1 and LT=1, GN is compared with the user global bit when U=1 and with the supervisor global bit when U=0. Equal gives OK and unequal gives TRAP.
- R7: The global bits come from `s_gen_user`/`s_gen_sup` when `HAS_SMODE`=1, and from `m_gen_user`/`m_gen_sup` otherwise.
- R8: Data reads, writes, execute and every failing check report `res_lc`=0. `res_pass` is 1 exactly when `res_cause`=0.
- R9: With `SV32_MODE`=1, `ext_bits` is ignored and the value 0b1110000000 is used: stores are allowed and capability loads give OK.
- R10: Each check with `chk_valid` high yields `res_valid` high on the next cycle, with its results. Otherwise `res_valid` is low.
- R11: On each valid check, `acc_lc` becomes the larger of its base and the check's `res_lc`, taking OK<CLEAR<TRAP. The base is OK when `walk_start` is 1 and the previous `acc_lc` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_valid | input | 1 | A check is presented this cycle |
| walk_start | input | 1 | First level of a walk; the accumulator base is OK |
| pte_flags | input | 8 | Standard entry flags (V,R,W,X,U,G,A,D from bit 0) |
| ext_bits | input | 10 | Capability extension field |
| acc_op | input | 2 | Access kind |
| rd_is_cap | input | 1 | The read half carries a capability |
| wr_is_cap | input | 1 | The write half carries a capability |
| priv_sup | input | 1 | 1 = supervisor, 0 = user |
| mxr | input | 1 | Executable pages readable |
| sum | input | 1 | Supervisor may touch user pages |
| s_gen_user | input | 1 | Supervisor-register user generation bit |
| s_gen_sup | input | 1 | Supervisor-register supervisor generation bit |
| m_gen_user | input | 1 | Machine-register user generation bit |
| m_gen_sup | input | 1 | Machine-register supervisor generation bit |
| res_valid | output | 1 | Result valid |
| res_pass | output | 1 | Check passed |
| res_cause | output | 2 | 0 none, 1 invalid, 2 no permission, 3 capability error |
| res_lc | output | 2 | Load mode of this check |
| acc_lc | output | 2 | Walk-wide accumulated load mode |

## Verification
Three copies of the block run side by side on the same stimulus: the default build, a build that reads the machine-level generation bits, and a build without an extension field. Each reserved combination of the extension bits is tried one at a time, and so is each base-permission failure. Base-permission failures are paired with a cleared store-enable bit, which shows whether the priority between causes is right. Capability loads sweep every legal load encoding and every user-bit and generation pairing; this separates the user global bit from the supervisor one, and the match case from the mismatch case. Walk sequences climb and then try to drop the accumulated mode, and restart it mid-stream, which shows whether the join is monotonic and whether it resets.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  typedef enum logic [1:0] {LC_OK = 2'd0, LC_CLEAR = 2'd1, LC_TRAP = 2'd2} lc_mode_e;
  typedef enum logic [1:0] {CZ_NONE = 2'd0, CZ_INVALID = 2'd1, CZ_NOPERM = 2'd2, CZ_CAPERR = 2'd3} cause_e;
  typedef enum logic [1:0] {OP_READ = 2'd0, OP_WRITE = 2'd1, OP_RMW = 2'd2, OP_EXEC = 2'd3} op_e;

  localparam int F_V = 0;
  localparam int F_R = 1;
  localparam int F_W = 2;
  localparam int F_X = 3;
  localparam int F_U = 4;

  localparam int E_SE = 9;
  localparam int E_LE = 8;
  localparam int E_LT = 6;
  localparam int E_GN = 5;

  function automatic lc_mode_e lc_join(input lc_mode_e a, input lc_mode_e b);
    if (a == LC_TRAP || b == LC_TRAP)       return LC_TRAP;
    else if (a == LC_CLEAR || b == LC_CLEAR) return LC_CLEAR;
    else                                     return LC_OK;
  endfunction
endpackage

// File: rtl/cpc_base_perm.sv
module cpc_base_perm
  import cpc_pkg::*;
#(
  parameter int FLAG_W = 8
) (
  input  logic [FLAG_W-1:0] flags,
  input  op_e               op,
  input  logic              priv_sup,
  input  logic              mxr,
  input  logic              sum,
  output logic              base_ok
);
  logic rd_ok, wr_ok, x_ok, priv_ok, unused_flags;

  assign unused_flags = ^{flags[FLAG_W-1:F_U+1], flags[F_V]};
  assign rd_ok = flags[F_R] | (flags[F_X] & mxr);
  assign wr_ok = flags[F_W];
  assign x_ok  = flags[F_X];
  assign priv_ok = priv_sup ? (!flags[F_U] | sum) : flags[F_U];

  always_comb begin
    unique case (op)
      OP_READ:  base_ok = priv_ok & rd_ok;
      OP_WRITE: base_ok = priv_ok & wr_ok;
      OP_RMW:   base_ok = priv_ok & rd_ok & wr_ok;
      default:  base_ok = x_ok & (priv_sup ? !flags[F_U] : flags[F_U]);
    endcase
  end
endmodule

// File: rtl/cpc_ext_decode.sv
module cpc_ext_decode
  import cpc_pkg::*;
#(
  parameter bit SV32_MODE = 1'b0,
  parameter int EXT_W     = 10
) (
  input  logic [EXT_W-1:0] ext_in,
  input  logic             pte_user,
  input  logic             gen_user,
  input  logic             gen_sup,
  output logic             ext_bad,
  output logic             store_ok,
  output lc_mode_e         lc_raw
);
  localparam logic [EXT_W-1:0] FIXED_EXT = EXT_W'(10'b1110000000);
  logic [EXT_W-1:0] eff;
  logic le, lt, gn, gsel, unused_ext;

  generate
    if (SV32_MODE) begin : g_fixed
      assign eff = FIXED_EXT;
      assign unused_ext = ^ext_in;
    end else begin : g_field
      assign eff = ext_in;
      assign unused_ext = 1'b0;
    end
  endgenerate

  logic unused_rest;
  assign unused_rest = ^{eff[EXT_W-1:E_SE+1], eff[E_LE-1], eff[E_GN-1:0], unused_ext};

  assign le = eff[E_LE];
  assign lt = eff[E_LT];
  assign gn = eff[E_GN];
  assign store_ok = eff[E_SE];
  assign ext_bad  = gn & (!le | !lt);
  assign gsel     = pte_user ? gen_user : gen_sup;

  always_comb begin
    unique case ({le, lt})
      2'b00:   lc_raw = LC_CLEAR;
      2'b01:   lc_raw = LC_TRAP;
      2'b10:   lc_raw = LC_OK;
      default: lc_raw = (gn == gsel) ? LC_OK : LC_TRAP;
    endcase
  end
endmodule

// File: rtl/cap_pte_checker.sv
module cap_pte_checker
  import cpc_pkg::*;
#(
  parameter bit SV32_MODE = 1'b0,
  parameter bit HAS_SMODE = 1'b1,
  parameter int EXT_W     = 10,
  parameter int FLAG_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chk_valid,
  input  logic              walk_start,
  input  logic [FLAG_W-1:0] pte_flags,
  input  logic [EXT_W-1:0]  ext_bits,
  input  logic [1:0]        acc_op,
  input  logic              rd_is_cap,
  input  logic              wr_is_cap,
  input  logic              priv_sup,
  input  logic              mxr,
  input  logic              sum,
  input  logic              s_gen_user,
  input  logic              s_gen_sup,
  input  logic              m_gen_user,
  input  logic              m_gen_sup,
  output logic              res_valid,
  output logic              res_pass,
  output logic [1:0]        res_cause,
  output logic [1:0]        res_lc,
  output logic [1:0]        acc_lc
);
  op_e      op;
  logic     base_ok, ext_bad, store_ok, entry_bad, rd_cap_op, wr_cap_op;
  logic     g_user, g_sup, unused_gen;
  lc_mode_e lc_raw, lc_now, acc_q, acc_base;
  cause_e   cause_now;

  assign op = op_e'(acc_op);
  assign rd_cap_op = rd_is_cap & (op == OP_READ || op == OP_RMW);
  assign wr_cap_op = wr_is_cap & (op == OP_WRITE || op == OP_RMW);

  generate
    if (HAS_SMODE) begin : g_sreg
      assign g_user = s_gen_user;
      assign g_sup  = s_gen_sup;
      assign unused_gen = m_gen_user ^ m_gen_sup;
    end else begin : g_mreg
      assign g_user = m_gen_user;
      assign g_sup  = m_gen_sup;
      assign unused_gen = s_gen_user ^ s_gen_sup;
    end
  endgenerate

  cpc_base_perm #(.FLAG_W(FLAG_W)) u_base (
    .flags(pte_flags), .op(op), .priv_sup(priv_sup), .mxr(mxr), .sum(sum),
    .base_ok(base_ok)
  );

  cpc_ext_decode #(.SV32_MODE(SV32_MODE), .EXT_W(EXT_W)) u_ext (
    .ext_in(ext_bits), .pte_user(pte_flags[F_U]), .gen_user(g_user), .gen_sup(g_sup),
    .ext_bad(ext_bad), .store_ok(store_ok), .lc_raw(lc_raw)
  );

  assign entry_bad = !pte_flags[F_V] | (pte_flags[F_W] & !pte_flags[F_R]) | ext_bad;

  always_comb begin
    if (entry_bad)                  cause_now = CZ_INVALID;
    else if (!base_ok)              cause_now = CZ_NOPERM;
    else if (wr_cap_op && !store_ok) cause_now = CZ_CAPERR;
    else                            cause_now = CZ_NONE;
  end

  assign lc_now   = (cause_now == CZ_NONE && rd_cap_op) ? lc_raw : LC_OK;
  assign acc_base = walk_start ? LC_OK : acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_pass  <= 1'b0;
      res_cause <= CZ_NONE;
      res_lc    <= LC_OK;
      acc_q     <= LC_OK;
    end else begin
      res_valid <= chk_valid;
      if (chk_valid) begin
        res_pass  <= (cause_now == CZ_NONE);
        res_cause <= cause_now;
        res_lc    <= lc_now;
        acc_q     <= lc_join(acc_base, lc_now);
      end
    end
  end

  assign acc_lc = acc_q;

  // R10: a result follows each presented check by one cycle
  a_r10_result_timing: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> res_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> !res_valid);
  // R8: a failed check reports the OK load mode
  a_r8_fail_mode_ok: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_pass) |-> (res_lc == 2'd0));
  // R11: without a restart the accumulated mode never falls
  a_r11_monotonic: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && !walk_start) |=> (acc_lc >= $past(acc_lc)));
  // R11: TRAP stays until a restart
  a_r11_trap_holds: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && !walk_start && acc_lc == 2'd2) |=> (acc_lc == 2'd2));
  // R10: outputs hold when no check is presented
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!chk_valid && res_valid) |=> $stable(acc_lc));

  logic unused_top;
  assign unused_top = unused_gen;
endmodule

// File: tb/sim_cap_pte_checker.sv
module sim_cap_pte_checker;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic       chk_valid = 0, walk_start = 0;
  logic [7:0] pte_flags = 0;
  logic [9:0] ext_bits = 0;
  logic [1:0] acc_op = 0;
  logic rd_is_cap = 0, wr_is_cap = 0, priv_sup = 0, mxr = 0, sum = 0;
  logic s_gu = 0, s_gs = 0, m_gu = 0, m_gs = 0;

  logic       rv [3];
  logic       rp [3];
  logic [1:0] rc [3];
  logic [1:0] rl [3];
  logic [1:0] ra [3];

  cap_pte_checker u0 (.clk, .rst, .chk_valid, .walk_start, .pte_flags, .ext_bits, .acc_op,
    .rd_is_cap, .wr_is_cap, .priv_sup, .mxr, .sum, .s_gen_user(s_gu), .s_gen_sup(s_gs),
    .m_gen_user(m_gu), .m_gen_sup(m_gs), .res_valid(rv[0]), .res_pass(rp[0]),
    .res_cause(rc[0]), .res_lc(rl[0]), .acc_lc(ra[0]));
  cap_pte_checker #(.HAS_SMODE(1'b0)) u1 (.clk, .rst, .chk_valid, .walk_start, .pte_flags,
    .ext_bits, .acc_op, .rd_is_cap, .wr_is_cap, .priv_sup, .mxr, .sum, .s_gen_user(s_gu),
    .s_gen_sup(s_gs), .m_gen_user(m_gu), .m_gen_sup(m_gs), .res_valid(rv[1]), .res_pass(rp[1]),
    .res_cause(rc[1]), .res_lc(rl[1]), .acc_lc(ra[1]));
  cap_pte_checker #(.SV32_MODE(1'b1)) u2 (.clk, .rst, .chk_valid, .walk_start, .pte_flags,
    .ext_bits, .acc_op, .rd_is_cap, .wr_is_cap, .priv_sup, .mxr, .sum, .s_gen_user(s_gu),
    .s_gen_sup(s_gs), .m_gen_user(m_gu), .m_gen_sup(m_gs), .res_valid(rv[2]), .res_pass(rp[2]),
    .res_cause(rc[2]), .res_lc(rl[2]), .acc_lc(ra[2]));

  typedef struct packed { logic [1:0] cause; logic [1:0] lc; logic [1:0] acc; } exp_t;
  typedef struct packed { exp_t e2; exp_t e1; exp_t e0; } item_t;
  item_t      sb_q[$];
  string      tag_q[$];
  int         checks = 0, errors = 0;
  logic [1:0] acc_m [3];
  bit         done = 0;

  localparam logic [7:0] V = 8'h01, R = 8'h02, W = 8'h04, X = 8'h08, U = 8'h10;
  localparam logic [9:0] SE = 10'h200, LE = 10'h100, LT = 10'h040, GN = 10'h020;

  function automatic logic [3:0] model(input bit sv32, input bit hsm);
    logic [9:0] e;
    logic cr, crt, crg, inval, rdok, wrok, pok, base, rdc, wrc, g;
    logic [1:0] cz, lc;
    e = sv32 ? 10'b1110000000 : ext_bits;
    cr = e[8]; crt = e[6]; crg = e[5];
    inval = !pte_flags[0] || (pte_flags[2] && !pte_flags[1]) || (!cr && crg) || (cr && crg && !crt);
    rdok = pte_flags[1] || (pte_flags[3] && mxr);
    wrok = pte_flags[2];
    pok = priv_sup ? (!pte_flags[4] || sum) : pte_flags[4];
    case (acc_op)
      2'd0: base = pok && rdok;
      2'd1: base = pok && wrok;
      2'd2: base = pok && rdok && wrok;
      default: base = pte_flags[3] && (priv_sup ? !pte_flags[4] : pte_flags[4]);
    endcase
    rdc = rd_is_cap && (acc_op == 2'd0 || acc_op == 2'd2);
    wrc = wr_is_cap && (acc_op == 2'd1 || acc_op == 2'd2);
    if (inval) cz = 2'd1;
    else if (!base) cz = 2'd2;
    else if (wrc && !e[9]) cz = 2'd3;
    else cz = 2'd0;
    g = hsm ? (pte_flags[4] ? s_gu : s_gs) : (pte_flags[4] ? m_gu : m_gs);
    if (cz != 0 || !rdc) lc = 2'd0;
    else if (!cr && !crt) lc = 2'd1;
    else if (!cr && crt) lc = 2'd2;
    else if (cr && !crt) lc = 2'd0;
    else lc = (crg == g) ? 2'd0 : 2'd2;
    return {cz, lc};
  endfunction

  function automatic logic [1:0] jn(input logic [1:0] a, input logic [1:0] b);
    return (a > b) ? a : b;
  endfunction

  task automatic drive(input string tag, input logic st, input logic [7:0] f, input logic [9:0] e,
                       input logic [1:0] op, input logic rc_, input logic wc_, input logic sup,
                       input logic mx = 0, input logic sm = 0, input logic [3:0] gens = 4'b0);
    item_t it;
    exp_t  ex [3];
    @(negedge clk);
    chk_valid = 1; walk_start = st; pte_flags = f; ext_bits = e; acc_op = op;
    rd_is_cap = rc_; wr_is_cap = wc_; priv_sup = sup; mxr = mx; sum = sm;
    {s_gu, s_gs, m_gu, m_gs} = gens;
    for (int i = 0; i < 3; i++) begin
      logic [3:0] r;
      r = model(i == 2, i != 1);
      acc_m[i] = jn(st ? 2'd0 : acc_m[i], r[1:0]);
      ex[i] = '{cause: r[3:2], lc: r[1:0], acc: acc_m[i]};
    end
    it.e0 = ex[0]; it.e1 = ex[1]; it.e2 = ex[2];
    sb_q.push_back(it);
    tag_q.push_back(tag);
  endtask

  task automatic cmp(input string tag, input int inst, input exp_t ex);
    checks++;
    if (rv[inst] !== 1'b1 || rc[inst] !== ex.cause || rl[inst] !== ex.lc || ra[inst] !== ex.acc ||
        rp[inst] !== (ex.cause == 2'd0)) begin
      errors++;
      $display("FAIL %s u%0d: got v=%b pass=%b cause=%0d lc=%0d acc=%0d, expected cause=%0d lc=%0d acc=%0d",
               tag, inst, rv[inst], rp[inst], rc[inst], rl[inst], ra[inst], ex.cause, ex.lc, ex.acc);
    end
  endtask

  // monitor: pops one expected item per result
  always @(negedge clk) begin
    if (!rst && rv[0] === 1'b1) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10: result with no pending check, got valid=1 expected 0");
      end else begin
        item_t it;
        string t;
        it = sb_q.pop_front();
        t = tag_q.pop_front();
        cmp(t, 0, it.e0);
        cmp(t, 1, it.e1);
        cmp(t, 2, it.e2);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) acc_m[i] = 2'd0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      checks++;
      if (rv[i] !== 1'b0 || ra[i] !== 2'd0) begin
        errors++;
        $display("FAIL R1 u%0d: got valid=%b acc=%0d, expected valid=0 acc=0", i, rv[i], ra[i]);
      end
    end
    // R2: reserved and invalid encodings
    drive("R2 v0",      1, R,         SE|LE,    2'd0, 0, 0, 1);
    drive("R2 w-no-r",  1, V|W,       SE|LE,    2'd1, 0, 0, 1);
    drive("R2 le0-gn",  1, V|R,       GN,       2'd0, 1, 0, 1);
    drive("R2 le1-gn",  1, V|R,       LE|GN,    2'd0, 1, 0, 1);
    // R3: base permission and its priority
    drive("R3 user-on-sup", 1, V|R|W, LE,       2'd0, 0, 0, 0);
    drive("R3 prio",        1, V|R,   LE,       2'd1, 0, 1, 1);
    drive("R3 sum-off",     1, V|R|U, SE|LE,    2'd0, 0, 0, 1);
    drive("R3 sum-on",      1, V|R|U, SE|LE,    2'd0, 0, 0, 1, 0, 1);
    drive("R3 mxr",         1, V|X,   SE|LE,    2'd0, 1, 0, 1, 1);
    drive("R3 sup-exec-u",  1, V|X|U, SE|LE,    2'd3, 0, 0, 1, 0, 1);
    drive("R3 user-exec",   1, V|X|U, SE|LE,    2'd3, 0, 0, 0);
    // R4: store gating
    drive("R4 cap-store",   1, V|R|W, LE,       2'd1, 0, 1, 1);
    drive("R4 data-store",  1, V|R|W, LE,       2'd1, 0, 0, 1);
    drive("R4 rmw-cap",     1, V|R|W, LE,       2'd2, 1, 1, 1);
    drive("R4 store-ok",    1, V|R|W, SE|LE,    2'd1, 0, 1, 1);
    // R5: load modes
    drive("R5 clear",       1, V|R,   SE,       2'd0, 1, 0, 1);
    drive("R5 trap",        1, V|R,   SE|LT,    2'd0, 1, 0, 1);
    drive("R5 ok",          1, V|R,   SE|LE,    2'd0, 1, 0, 1);
    drive("R5 rmw-read",    1, V|R|W, SE|LT,    2'd2, 1, 0, 1);
    // R6/R7: generation compare, gens = {s_u,s_s,m_u,m_s}
    drive("R6 sup-match",   1, V|R,   LE|LT,    2'd0, 1, 0, 1, 0, 0, 4'b1000);
    drive("R6 sup-miss",    1, V|R,   LE|LT,    2'd0, 1, 0, 1, 0, 0, 4'b0100);
    drive("R6 usr-match",   1, V|R|U, LE|LT|GN, 2'd0, 1, 0, 0, 0, 0, 4'b1000);
    drive("R6 usr-miss",    1, V|R|U, LE|LT|GN, 2'd0, 1, 0, 0, 0, 0, 4'b0111);
    drive("R7 mreg",        1, V|R|U, LE|LT|GN, 2'd0, 1, 0, 0, 0, 0, 4'b0010);
    drive("R7 mreg-sup",    1, V|R,   LE|LT|GN, 2'd0, 1, 0, 1, 0, 0, 4'b1101);
    // R8: data and execute paths ignore load bits
    drive("R8 data-read",   1, V|R,   LT,       2'd0, 0, 0, 1);
    drive("R8 exec",        1, V|X,   0,        2'd3, 1, 1, 1);
    drive("R8 fail-mode",   1, V|R,   0,        2'd1, 0, 0, 1);
    // R9: fixed field variant is the third instance throughout
    drive("R9 ignored",     1, V|R|W, 10'h000,  2'd2, 1, 1, 1);
    // R11: accumulator across levels
    drive("R11 lvl0-clr",   1, V|R,   SE,       2'd0, 1, 0, 1);
    drive("R11 lvl1-ok",    0, V|R,   SE|LE,    2'd0, 1, 0, 1);
    drive("R11 lvl2-trap",  0, V|R,   SE|LT,    2'd0, 1, 0, 1);
    drive("R11 lvl3-clr",   0, V|R,   SE,       2'd0, 1, 0, 1);
    drive("R11 lvl4-fail",  0, R,     SE,       2'd0, 1, 0, 1);
    drive("R11 restart",    1, V|R,   SE|LE,    2'd0, 1, 0, 1);
    drive("R11 fail-start", 1, V,     SE,       2'd0, 1, 0, 1);
    @(negedge clk);
    chk_valid = 0;
    repeat (3) @(negedge clk);
    // R10: queue fully drained, nothing spurious
    checks++;
    if (sb_q.size() != 0 || rv[0] !== 1'b0) begin
      errors++;
      $display("FAIL R10: got pending=%0d valid=%b, expected pending=0 valid=0", sb_q.size(), rv[0]);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule